// File: doc/BRIEF.md
# Triggered Frame Sample Counter

This block decides when an acquisition path takes samples. A trigger starts a frame. It can come from three places: an internal interval timer, an external digital line, or the output of an external comparator. During the frame the block passes sample clock ticks through as sample enables. It counts those ticks down from a programmed 24-bit value. When the count is used up, it raises a one-cycle frame-done pulse and reloads the programmed length, ready for the next trigger.

Four run modes are available:
- **Single:** accepts one trigger and then holds.
- **Continuous:** re-arms after every frame.
- **Free-run:** the counter is disabled, so sampling runs without end once triggered.
- **Pretrigger:** samples freely before the trigger and starts the countdown only when the trigger arrives.

The present state and the live count are output as status.

The external inputs pass through a synchronizer and a rising-edge detector. The timer pulse is already synchronous. One multiplexer then picks the active source, so every source causes the same start action. Sample ticks come from the sample clock domain as a one-cycle strobe in the system clock domain.

Top module: `frame_trig_ctrl`

## Requirements
- R1: While reset is asserted and in the cycles after reset with the enable low, the state output reads 0 (idle), sample_en and frame_done are 0 and cur_count reads 0 until the first reload.
- R2: A counted frame asserts sample_en on exactly cfg_count+1 sample ticks. The count steps down by one on each tick. The cycle after the tick taken at count 0, frame_done is high for exactly one cycle.
- R3: Sampling begins on the first sample tick after the trigger is recognised. No sample_en occurs in the idle (0), armed (1) or done (4) states.
- R4: Once a frame is counting, further trigger edges are ignored. The frame length is unchanged and only one frame_done results.
- R5: In single mode (cfg_mode=0), after the frame ends the state stays at done (4). Later triggers start no frame and produce no sample_en.
- R6: In continuous mode (cfg_mode=1), the block returns to armed (1) after each frame, with the count reloaded. With the timer source (cfg_src=0), a trigger is issued every cfg_interval+1 clock cycles, so successive frame_done pulses are that many cycles apart.
- R7: In free-run mode (cfg_mode=2), after the trigger the state stays at counting (3). sample_en follows every tick, cur_count stays at the loaded value and no frame_done is produced.
- R8: In pretrigger mode (cfg_mode=3), the block waits in state 2 and asserts sample_en on every tick with cur_count held. A trigger starts a countdown of cfg_count+1 ticks, after which the block returns to state 2.
- R9: Only the selected source triggers: cfg_src 0 = timer, 1 = ext_trig_in, 2 = cmp_trig_in, 3 = none.
- R10: An external trigger acts on its rising edge only. A level held high starts at most one frame.
- R11: Dropping cfg_enable returns the block to idle (0) on the next clock from any state. While idle, cur_count reloads cfg_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Arms the block; low forces idle |
| cfg_src | input | 2 | Trigger source select |
| cfg_mode | input | 2 | Run mode select |
| cfg_count | input | 24 | Frame length minus one, in sample ticks |
| cfg_interval | input | 16 | Timer period minus one, in clocks |
| ext_trig_in | input | 1 | Asynchronous external digital trigger |
| cmp_trig_in | input | 1 | Asynchronous comparator trigger |
| samp_tick | input | 1 | Sample clock strobe, one cycle per sample |
| sample_en | output | 1 | Sample enable for the converters |
| frame_done | output | 1 | One-cycle pulse after a frame ends |
| state_o | output | 3 | 0 idle, 1 armed, 2 pretrigger run, 3 counting, 4 done |
| cur_count | output | 24 | Live remaining count |

## Verification
The hardest case to reach from the ports is a second trigger edge that lands inside a frame which is already counting. The synchronizer delay and a tick rate below the clock rate must both be accounted for to place that edge mid-frame. The bench runs the ticks at half rate, so a ten-tick frame spans about twenty clocks. It pulses the comparator line once to start the frame, then again eight clocks later. The scoreboard must then see a single frame of the original length. Timer-driven frames are checked for spacing by recording the cycle of each frame_done.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ARMED    = 3'd1,
    ST_PRETRIG  = 3'd2,
    ST_COUNTING = 3'd3,
    ST_DONE     = 3'd4
  } fts_state_e;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_CONT   = 2'd1,
    MD_FREE   = 2'd2,
    MD_PRE    = 2'd3
  } fts_mode_e;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_CMP   = 2'd2,
    SRC_NONE  = 2'd3
  } fts_src_e;
endpackage

// File: rtl/fts_edge_sync.sv
module fts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fts_interval_timer.sv
module fts_interval_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] interval,
  output logic             pulse_o
);
  localparam logic [TMR_W-1:0] T_ONE = TMR_W'(1);
  logic [TMR_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tcnt    <= '0;
      pulse_o <= 1'b0;
    end else if (tcnt == interval) begin
      tcnt    <= '0;
      pulse_o <= 1'b1;
    end else begin
      tcnt    <= tcnt + T_ONE;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fts_frame_fsm.sv
module fts_frame_fsm
  import fts_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             trig,
  input  logic             samp_tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [2:0]       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sample_en_o,
  output logic             term_tick_o,
  output logic             frame_done_o
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  fts_state_e st, nxt;
  fts_mode_e  md;
  logic [CNT_W-1:0] cnt;

  assign md = fts_mode_e'(mode);

  function automatic logic [CNT_W-1:0] next_count(
    input fts_state_e       s,
    input fts_mode_e        m,
    input logic             tick,
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] ld
  );
    if (s == ST_COUNTING) begin
      if (m != MD_FREE && tick && c != '0) return c - C_ONE;
      return c;
    end
    return ld;
  endfunction

  assign term_tick_o = (st == ST_COUNTING) && (md != MD_FREE) && samp_tick && (cnt == '0);
  assign sample_en_o = samp_tick && (st == ST_COUNTING || st == ST_PRETRIG);

  always_comb begin
    nxt = st;
    if (!enable) nxt = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:     nxt = (md == MD_PRE) ? ST_PRETRIG : ST_ARMED;
        ST_ARMED:    if (trig) nxt = ST_COUNTING;
        ST_PRETRIG:  if (trig) nxt = ST_COUNTING;
        ST_COUNTING: if (term_tick_o) nxt = ST_DONE;
        ST_DONE: begin
          if (md == MD_SINGLE)   nxt = ST_DONE;
          else if (md == MD_PRE) nxt = ST_PRETRIG;
          else                   nxt = ST_ARMED;
        end
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      frame_done_o <= 1'b0;
    end else begin
      st           <= nxt;
      cnt          <= next_count(st, md, samp_tick, cnt, load_val);
      frame_done_o <= term_tick_o;
    end
  end

  assign state_o = st;
  assign cnt_o   = cnt;
endmodule

// File: rtl/frame_trig_ctrl.sv
module frame_trig_ctrl
  import fts_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_src,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [TMR_W-1:0] cfg_interval,
  input  logic             ext_trig_in,
  input  logic             cmp_trig_in,
  input  logic             samp_tick,
  output logic             sample_en,
  output logic             frame_done,
  output logic [2:0]       state_o,
  output logic [CNT_W-1:0] cur_count
);
  localparam int N_EXT = 2;

  logic [N_EXT-1:0] ext_raw;
  logic [N_EXT-1:0] ext_rise;
  logic             tmr_pulse;
  logic             trig_start;
  logic             term_tick;

  assign ext_raw = {cmp_trig_in, ext_trig_in};

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    fts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_raw[g]),
      .rise_o  (ext_rise[g])
    );
  end

  fts_interval_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_enable),
    .interval(cfg_interval),
    .pulse_o (tmr_pulse)
  );

  always_comb begin
    unique case (fts_src_e'(cfg_src))
      SRC_TIMER: trig_start = tmr_pulse;
      SRC_EXT:   trig_start = ext_rise[0];
      SRC_CMP:   trig_start = ext_rise[1];
      default:   trig_start = 1'b0;
    endcase
  end

  fts_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .mode        (cfg_mode),
    .trig        (trig_start),
    .samp_tick   (samp_tick),
    .load_val    (cfg_count),
    .state_o     (state_o),
    .cnt_o       (cur_count),
    .sample_en_o (sample_en),
    .term_tick_o (term_tick),
    .frame_done_o(frame_done)
  );
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [1:0]       cfg_mode,
  input logic             samp_tick,
  input logic             frame_done,
  input logic             term_tick,
  input logic [2:0]       state_o,
  input logic [CNT_W-1:0] cur_count
);
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R2

  AST_DONE_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cur_count) == '0); // R2

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && cfg_mode != 2'd2 && samp_tick && cur_count != '0)
      |=> cur_count == $past(cur_count) - CNT_W'(1)); // R2

  AST_FRAME_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && cfg_enable && !term_tick) |=> state_o == 3'd3); // R4

  AST_SINGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && cfg_mode == 2'd0 && cfg_enable) |=> state_o == 3'd4); // R5

  AST_FREE_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && cfg_mode == 2'd2) |=> $stable(cur_count)); // R7

  AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> state_o == 3'd0); // R11
endmodule

bind frame_trig_ctrl fts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_enable(cfg_enable),
  .cfg_mode  (cfg_mode),
  .samp_tick (samp_tick),
  .frame_done(frame_done),
  .term_tick (term_tick),
  .state_o   (state_o),
  .cur_count (cur_count)
);

// File: tb/frame_trig_ctrl_tb.sv
module frame_trig_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_src = 2'd0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [23:0] cfg_count = 24'd0;
  logic [15:0] cfg_interval = 16'd0;
  logic        ext_trig = 1'b0;
  logic        cmp_trig = 1'b0;
  logic        samp_tick = 1'b0;
  logic        sample_en, frame_done;
  logic [2:0]  state_o;
  logic [23:0] cur_count;

  int vectors = 0, miscompares = 0;
  int exp_q[$];
  int run_cnt = 0, stray = 0, frames_seen = 0, pre_ticks = 0, se_total = 0;
  int tick_div = 1, phase = 0;
  longint cyc = 0, done_last = 0, done_prev = 0;
  bit finished = 0;

  frame_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_interval(cfg_interval),
    .ext_trig_in(ext_trig), .cmp_trig_in(cmp_trig), .samp_tick(samp_tick),
    .sample_en(sample_en), .frame_done(frame_done), .state_o(state_o),
    .cur_count(cur_count)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    phase = (phase + 1 >= tick_div) ? 0 : phase + 1;
    samp_tick = (phase == 0);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (state_o == 3'd0) run_cnt = 0;
      if (sample_en) se_total++;
      if (sample_en && state_o == 3'd3) run_cnt++;
      if (sample_en && state_o == 3'd2) pre_ticks++;
      if (sample_en && (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd4)) stray++;
      if (frame_done) begin
        frames_seen++;
        done_prev = done_last;
        done_last = cyc;
        if (exp_q.size() == 0) chk("R2 unexpected frame", 1, 0);
        else chk("R2 frame length", run_cnt, exp_q.pop_front());
        run_cnt = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_frames(input int target);
    int k = 0;
    while (frames_seen < target && k < 3000) begin
      step(1);
      k++;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    int base;
    int s0;
    step(3);
    // R1: reset state
    chk("R1 state", state_o, 0);
    chk("R1 sample_en", sample_en, 0);
    chk("R1 frame_done", frame_done, 0);
    chk("R1 count", cur_count, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 idle after reset", state_o, 0);

    // single mode, external source
    cfg_mode = 2'd0; cfg_src = 2'd1; cfg_count = 24'd4; tick_div = 1;
    cfg_enable = 1'b1;
    step(4);
    chk("R3 armed waits", state_o, 1);
    exp_q.push_back(5);
    ext_trig = 1'b1; step(3); ext_trig = 1'b0;
    wait_frames(1);
    step(2);
    chk("R5 single holds done", state_o, 4);
    ext_trig = 1'b1; step(3); ext_trig = 1'b0;
    step(20);
    chk("R5 no retrigger", frames_seen, 1);
    chk("R5 still done", state_o, 4);

    // R11 disable
    cfg_enable = 1'b0; cfg_count = 24'd9;
    step(3);
    chk("R11 idle", state_o, 0);
    chk("R11 reload", cur_count, 9);

    // continuous, comparator source, half-rate ticks
    cfg_mode = 2'd1; cfg_src = 2'd2; tick_div = 2;
    cfg_enable = 1'b1;
    step(4);
    base = frames_seen;
    exp_q.push_back(10);
    cmp_trig = 1'b1;
    wait_frames(base + 1);
    step(40);
    chk("R10 held level one frame", frames_seen, base + 1);
    chk("R6 rearmed", state_o, 1);
    cmp_trig = 1'b0; step(5);
    // R9 unselected source ignored
    ext_trig = 1'b1; step(3); ext_trig = 1'b0;
    step(20);
    chk("R9 ext ignored when cmp selected", frames_seen, base + 1);
    chk("R9 still armed", state_o, 1);
    // R4 lockout
    exp_q.push_back(10);
    cmp_trig = 1'b1; step(3); cmp_trig = 1'b0;
    step(5);
    cmp_trig = 1'b1; step(2); cmp_trig = 1'b0;
    wait_frames(base + 2);
    step(40);
    chk("R4 one frame under retrigger", frames_seen, base + 2);
    cfg_enable = 1'b0; step(3);

    // continuous, timer source
    cfg_src = 2'd0; cfg_count = 24'd3; cfg_interval = 16'd29; tick_div = 1;
    base = frames_seen;
    repeat (3) exp_q.push_back(4);
    cfg_enable = 1'b1;
    wait_frames(base + 3);
    cfg_enable = 1'b0;
    chk("R6 timer frames", frames_seen, base + 3);
    chk("R6 frame spacing", done_last - done_prev, 30);
    step(3);

    // free-run
    cfg_mode = 2'd2; cfg_src = 2'd1; cfg_count = 24'd7;
    base = frames_seen;
    cfg_enable = 1'b1; step(3);
    ext_trig = 1'b1; step(3); ext_trig = 1'b0;
    step(10);
    chk("R7 counting state", state_o, 3);
    s0 = se_total; step(20);
    chk("R7 every tick enabled", se_total - s0, 20);
    chk("R7 count held", cur_count, 7);
    chk("R7 no frame_done", frames_seen, base);
    cfg_enable = 1'b0; step(3);

    // pretrigger
    cfg_mode = 2'd3; cfg_count = 24'd5;
    cfg_enable = 1'b1; step(10);
    chk("R8 pretrig state", state_o, 2);
    s0 = pre_ticks; step(10);
    chk("R8 pretrig sampling", pre_ticks - s0, 10);
    chk("R8 count held", cur_count, 5);
    exp_q.push_back(6);
    ext_trig = 1'b1; step(3); ext_trig = 1'b0;
    wait_frames(base + 1);
    step(3);
    chk("R8 back to pretrig", state_o, 2);
    cfg_enable = 1'b0; step(3);

    // source none
    cfg_mode = 2'd0; cfg_src = 2'd3;
    base = frames_seen;
    cfg_enable = 1'b1; step(3);
    ext_trig = 1'b1; cmp_trig = 1'b1; step(3); ext_trig = 1'b0; cmp_trig = 1'b0;
    step(40);
    chk("R9 none selected", state_o, 1);
    chk("R9 no frame", frames_seen, base);
    cfg_enable = 1'b0; step(3);

    chk("R2 all frames seen", exp_q.size(), 0);
    chk("R3 no stray enables", stray, 0);
    finished = 1;
    summary();
  end
endmodule